// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Detection

This block is a register-mapped general-purpose I/O controller for a pin count that is a multiple of 32 (64 by default, 96 also supported). Every feature lives in its own array of 32-bit words, one word per 32 pins. Each pin has a direction bit, an output latch and a 2-bit alternate-function selector. The output latch is changed through separate write-one-to-set and write-one-to-clear words. Input levels are synchronised before they can be read back.

Each pin has its own rising-edge enable and falling-edge enable. An enabled edge sets a sticky status bit, and software clears that bit by writing a one to it. A single interrupt output is high while any status bit is set. Software reaches the block through a plain 32-bit word bus with separate write and read strobes. The pins appear as an input vector, an output vector and an output-enable vector. Pad multiplexing for the alternate functions lies outside the block.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every pin is an input (`pin_oe` all 0), the output latch is 0, all edge enables, status bits and alternate-function fields are 0, and `irq` is 0.
- R2: With W = PIN_COUNT/32, a feature's word for pin p sits at byte address (F·W + p/32)·4, and the pin is bit p%32 of that word. The feature index F is: 0 level, 1 direction, 2 set, 3 clear, 4 rising enable, 5 falling enable, 6 edge status, 7 alternate function. A read issued with `rd_en` at one clock edge shows its word on `rdata` after that edge.
- R3: A direction bit of 1 drives the matching `pin_oe` bit high (output), and 0 makes the pin an input. The direction words read back as written.
- R4: A write to a set word drives high each pin whose data bit is 1. A write to a clear word drives low each pin whose data bit is 1. Data bits of 0 leave their pins unchanged. Reads of set or clear words return the current output latch.
- R5: The level words return `pin_in` after a two-flop synchroniser, so a change is readable at most three clock edges later. Writes to level words have no effect.
- R6: An edge is detected by comparing the synchronised level with its value one cycle earlier. Rising and falling enables are independent per pin, and with both set a pin detects either edge. An edge whose enable is 0 sets nothing.
- R7: An edge-status bit is set by an enabled edge and stays set until software writes 1 to it. Writing 0 to a status bit leaves it unchanged.
- R8: If an enabled edge and a write-one-to-clear reach the same status bit in the same cycle, the bit stays set.
- R9: `irq` is high exactly while at least one edge-status bit is set.
- R10: The alternate-function area holds 2·W words. Pin p's 2-bit field sits in area word p/16 at bit (p%16)·2 and reads back as written. Value 0 means plain GPIO use. The field does not change `pin_out` or `pin_oe`.
- R11: A read of any word address above the alternate-function area returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the word at `addr` |
| rd_en | input | 1 | Read strobe; `rdata` updates at the same edge |
| addr | input | ADDR_W | Byte address; bits [1:0] are ignored |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| pin_in | input | PIN_COUNT | Pad input levels, asynchronous |
| pin_out | output | PIN_COUNT | Output latch driven to the pads |
| pin_oe | output | PIN_COUNT | Output enable per pin (direction) |
| irq | output | 1 | OR of all edge-status bits |

## Verification
The assertions assume the bus drives `wr_en`, `addr` and `wdata` as clean synchronous values. They also assume `pin_in` is asynchronous only as far as the synchroniser allows, so the edge checks look at the synchronised pulses and not at raw pads. The bench changes `pin_in` and every bus signal only on falling clock edges, holds each strobe for one rising edge, and keeps reset asserted for several cycles before any check, so the past-cycle comparisons never see pre-reset values. The same-cycle edge-and-clear case is set up by counting synchroniser stages, so the clear strobe lands on the edge where the detection pulse is high.

// File: rtl/gpio_bank_pkg.sv
// Package: shared feature codes and word geometry for the banked GPIO controller.
// Assumes pin counts are multiples of 32.
package gpio_bank_pkg;

    localparam int WORD_BITS   = 32;
    localparam int AF_BITS     = 2;
    localparam int AF_PER_WORD = WORD_BITS / AF_BITS;

    // Feature index; the numeric order sets the address layout.
    typedef enum logic [3:0] {
        FEAT_LEVEL    = 4'd0,
        FEAT_DIR      = 4'd1,
        FEAT_SET      = 4'd2,
        FEAT_CLR      = 4'd3,
        FEAT_RISE_EN  = 4'd4,
        FEAT_FALL_EN  = 4'd5,
        FEAT_STATUS   = 4'd6,
        FEAT_ALTFN    = 4'd7,
        FEAT_NONE     = 4'd15
    } feat_e;

endpackage

// File: rtl/gpio_addr_decode.sv
// Module: gpio_addr_decode
// Splits a byte address into a feature code and a word index within that
// feature. Features 0..6 span NREG words each; the alternate-function area
// spans 2*NREG words. Any other address decodes to FEAT_NONE.
// Assumes: addr bits [1:0] carry no meaning.
module gpio_addr_decode
    import gpio_bank_pkg::*;
#(
    parameter int NREG   = 2,
    parameter int ADDR_W = 8,
    parameter int IDX_W  = 2
) (
    input  logic [ADDR_W-1:0] addr,
    output feat_e             feat,
    output logic [IDX_W-1:0]  idx
);

    localparam int PLAIN_FEATS = 7;
    localparam int AF_FIRST    = PLAIN_FEATS * NREG;
    localparam int AF_LAST     = AF_FIRST + 2 * NREG;

    // Purpose: range-compare the word number against each feature window.
    always_comb begin
        int w;
        w    = int'(addr[ADDR_W-1:2]);
        feat = FEAT_NONE;
        idx  = '0;
        for (int f = 0; f < PLAIN_FEATS; f++) begin
            if (w >= f * NREG && w < (f + 1) * NREG) begin
                feat = feat_e'(4'(f));
                idx  = IDX_W'(w - f * NREG);
            end
        end
        if (w >= AF_FIRST && w < AF_LAST) begin
            feat = FEAT_ALTFN;
            idx  = IDX_W'(w - AF_FIRST);
        end
    end

endmodule

// File: rtl/gpio_pin_sync.sv
// Module: gpio_pin_sync
// Two-flop synchroniser per pin, then a one-cycle-delayed copy that is
// compared with the synchronised level to give rise and fall pulses.
// Assumes: pin_in is asynchronous to clk; pulses last one cycle.
module gpio_pin_sync #(
    parameter int PIN_COUNT = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [PIN_COUNT-1:0] pin_in,
    output logic [PIN_COUNT-1:0] level,
    output logic [PIN_COUNT-1:0] rise,
    output logic [PIN_COUNT-1:0] fall
);

    genvar p;
    generate
        for (p = 0; p < PIN_COUNT; p++) begin : g_pin
            logic meta_q;
            logic sync_q;
            logic prev_q;

            // Purpose: metastability stage, synchronised stage, history stage.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    meta_q <= 1'b0;
                    sync_q <= 1'b0;
                    prev_q <= 1'b0;
                end else begin
                    meta_q <= pin_in[p];
                    sync_q <= meta_q;
                    prev_q <= sync_q;
                end
            end

            // Purpose: level and edge pulses from the synchronised stages.
            assign level[p] = sync_q;
            assign rise[p]  = sync_q & ~prev_q;
            assign fall[p]  = ~sync_q & prev_q;
        end
    endgenerate

endmodule

// File: rtl/gpio_reg_bank.sv
// Module: gpio_reg_bank
// Holds direction, output latch, edge enables, sticky edge status and the
// alternate-function fields. Applies the decoded bus write each cycle.
// An enabled edge takes priority over a write-one-to-clear to the same bit.
// Assumes: feat/idx come from gpio_addr_decode, so idx is in range.
module gpio_reg_bank
    import gpio_bank_pkg::*;
#(
    parameter int PIN_COUNT = 64,
    parameter int IDX_W     = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  feat_e                  feat,
    input  logic [IDX_W-1:0]       idx,
    input  logic [WORD_BITS-1:0]   wdata,
    input  logic [PIN_COUNT-1:0]   rise,
    input  logic [PIN_COUNT-1:0]   fall,
    output logic [PIN_COUNT-1:0]   dir_q,
    output logic [PIN_COUNT-1:0]   out_q,
    output logic [PIN_COUNT-1:0]   ren_q,
    output logic [PIN_COUNT-1:0]   fen_q,
    output logic [PIN_COUNT-1:0]   sts_q,
    output logic [2*PIN_COUNT-1:0] af_q
);

    logic [PIN_COUNT-1:0]   word_mask;
    logic [PIN_COUNT-1:0]   data_wide;
    logic [2*PIN_COUNT-1:0] af_mask;
    logic [2*PIN_COUNT-1:0] af_data;
    logic [PIN_COUNT-1:0]   hit;
    logic [PIN_COUNT-1:0]   clr_vec;

    // Purpose: place the bus word at its slot in pin-wide and field-wide vectors.
    always_comb begin
        int i;
        i         = int'(idx);
        word_mask = '0;
        data_wide = '0;
        af_mask   = '0;
        af_data   = '0;
        if (feat == FEAT_ALTFN) begin
            af_mask[i*WORD_BITS +: WORD_BITS] = '1;
            af_data[i*WORD_BITS +: WORD_BITS] = wdata;
        end else if (feat != FEAT_NONE) begin
            word_mask[i*WORD_BITS +: WORD_BITS] = '1;
            data_wide[i*WORD_BITS +: WORD_BITS] = wdata;
        end
    end

    // Purpose: enabled edges and the status clear mask for this cycle.
    assign hit     = (rise & ren_q) | (fall & fen_q);
    assign clr_vec = (wr_en && feat == FEAT_STATUS) ? data_wide : '0;

    // Purpose: configuration and output latch updates from bus writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= '0;
            out_q <= '0;
            ren_q <= '0;
            fen_q <= '0;
            af_q  <= '0;
        end else if (wr_en) begin
            unique case (feat)
                FEAT_DIR:     dir_q <= (dir_q & ~word_mask) | data_wide;
                FEAT_SET:     out_q <= out_q | data_wide;
                FEAT_CLR:     out_q <= out_q & ~data_wide;
                FEAT_RISE_EN: ren_q <= (ren_q & ~word_mask) | data_wide;
                FEAT_FALL_EN: fen_q <= (fen_q & ~word_mask) | data_wide;
                FEAT_ALTFN:   af_q  <= (af_q & ~af_mask) | af_data;
                default:      ;
            endcase
        end
    end

    // Purpose: sticky status, cleared by ones written, set by enabled edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts_q <= '0;
        end else begin
            sts_q <= (sts_q & ~clr_vec) | hit;
        end
    end

endmodule

// File: rtl/gpio_read_mux.sv
// Module: gpio_read_mux
// Selects the 32-bit word a read returns. Set and clear words return the
// output latch; FEAT_NONE returns zero.
// Assumes: idx is in range for the decoded feature.
module gpio_read_mux
    import gpio_bank_pkg::*;
#(
    parameter int PIN_COUNT = 64,
    parameter int IDX_W     = 2
) (
    input  feat_e                  feat,
    input  logic [IDX_W-1:0]       idx,
    input  logic [PIN_COUNT-1:0]   level,
    input  logic [PIN_COUNT-1:0]   dir_q,
    input  logic [PIN_COUNT-1:0]   out_q,
    input  logic [PIN_COUNT-1:0]   ren_q,
    input  logic [PIN_COUNT-1:0]   fen_q,
    input  logic [PIN_COUNT-1:0]   sts_q,
    input  logic [2*PIN_COUNT-1:0] af_q,
    output logic [WORD_BITS-1:0]   rd_word
);

    // Purpose: feature select followed by word slice.
    always_comb begin
        int i;
        i = int'(idx);
        unique case (feat)
            FEAT_LEVEL:           rd_word = level[i*WORD_BITS +: WORD_BITS];
            FEAT_DIR:             rd_word = dir_q[i*WORD_BITS +: WORD_BITS];
            FEAT_SET, FEAT_CLR:   rd_word = out_q[i*WORD_BITS +: WORD_BITS];
            FEAT_RISE_EN:         rd_word = ren_q[i*WORD_BITS +: WORD_BITS];
            FEAT_FALL_EN:         rd_word = fen_q[i*WORD_BITS +: WORD_BITS];
            FEAT_STATUS:          rd_word = sts_q[i*WORD_BITS +: WORD_BITS];
            FEAT_ALTFN:           rd_word = af_q[i*WORD_BITS +: WORD_BITS];
            default:              rd_word = '0;
        endcase
    end

endmodule

// File: rtl/gpio_bank_ctrl.sv
// Module: gpio_bank_ctrl (top)
// Banked GPIO controller: register-mapped direction, set/clear output
// latch, synchronised level readback, per-pin edge detection into sticky
// write-one-to-clear status, OR-combined interrupt, and 2-bit
// alternate-function fields.
// Assumes: PIN_COUNT is a multiple of 32; ADDR_W covers 9*PIN_COUNT/8 bytes.
module gpio_bank_ctrl
    import gpio_bank_pkg::*;
#(
    parameter int PIN_COUNT = 64,
    parameter int ADDR_W    = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [31:0]          wdata,
    output logic [31:0]          rdata,
    input  logic [PIN_COUNT-1:0] pin_in,
    output logic [PIN_COUNT-1:0] pin_out,
    output logic [PIN_COUNT-1:0] pin_oe,
    output logic                 irq
);

    localparam int NREG  = PIN_COUNT / WORD_BITS;
    localparam int IDX_W = (2 * NREG > 1) ? $clog2(2 * NREG) : 1;

    feat_e                  feat;
    logic [IDX_W-1:0]       idx;
    logic [PIN_COUNT-1:0]   level;
    logic [PIN_COUNT-1:0]   rise_pulse;
    logic [PIN_COUNT-1:0]   fall_pulse;
    logic [PIN_COUNT-1:0]   dir_q;
    logic [PIN_COUNT-1:0]   out_q;
    logic [PIN_COUNT-1:0]   ren_q;
    logic [PIN_COUNT-1:0]   fen_q;
    logic [PIN_COUNT-1:0]   sts_q;
    logic [2*PIN_COUNT-1:0] af_q;
    logic [WORD_BITS-1:0]   rd_word;

    gpio_addr_decode #(.NREG(NREG), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) dec_i (
        .addr (addr),
        .feat (feat),
        .idx  (idx)
    );

    gpio_pin_sync #(.PIN_COUNT(PIN_COUNT)) sync_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_in (pin_in),
        .level  (level),
        .rise   (rise_pulse),
        .fall   (fall_pulse)
    );

    gpio_reg_bank #(.PIN_COUNT(PIN_COUNT), .IDX_W(IDX_W)) bank_i (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .feat  (feat),
        .idx   (idx),
        .wdata (wdata),
        .rise  (rise_pulse),
        .fall  (fall_pulse),
        .dir_q (dir_q),
        .out_q (out_q),
        .ren_q (ren_q),
        .fen_q (fen_q),
        .sts_q (sts_q),
        .af_q  (af_q)
    );

    gpio_read_mux #(.PIN_COUNT(PIN_COUNT), .IDX_W(IDX_W)) rmux_i (
        .feat    (feat),
        .idx     (idx),
        .level   (level),
        .dir_q   (dir_q),
        .out_q   (out_q),
        .ren_q   (ren_q),
        .fen_q   (fen_q),
        .sts_q   (sts_q),
        .af_q    (af_q),
        .rd_word (rd_word)
    );

    // Purpose: register the read word at the strobe edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= rd_word;
        end
    end

    // Purpose: drive pads and combine status into the interrupt.
    assign pin_out = out_q;
    assign pin_oe  = dir_q;
    assign irq     = |sts_q;

endmodule

// File: rtl/gpio_bank_chk.sv
// Module: gpio_bank_chk
// Checker bound to gpio_bank_ctrl. Recomputes bus address windows on its
// own and relates writes, edge pulses and status over time.
// Assumes: bus inputs are synchronous to clk.
module gpio_bank_chk #(
    parameter int PIN_COUNT = 64,
    parameter int ADDR_W    = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_en,
    input logic [ADDR_W-1:0]    addr,
    input logic [31:0]          wdata,
    input logic [PIN_COUNT-1:0] pin_out,
    input logic [PIN_COUNT-1:0] pin_oe,
    input logic                 irq,
    input logic [PIN_COUNT-1:0] sts_q,
    input logic [PIN_COUNT-1:0] rise_pulse,
    input logic [PIN_COUNT-1:0] fall_pulse,
    input logic [PIN_COUNT-1:0] ren_q,
    input logic [PIN_COUNT-1:0] fen_q
);

    localparam int NREG = PIN_COUNT / 32;

    logic                 dir_wr;
    logic [PIN_COUNT-1:0] set_mask;
    logic [PIN_COUNT-1:0] clr_mask;
    logic [PIN_COUNT-1:0] hits;

    // Purpose: independent decode of direction, set and clear windows.
    always_comb begin
        int w;
        w        = int'(addr[ADDR_W-1:2]);
        dir_wr   = wr_en && w >= NREG && w < 2 * NREG;
        set_mask = '0;
        clr_mask = '0;
        if (wr_en && w >= 2 * NREG && w < 3 * NREG)
            set_mask[(w - 2 * NREG) * 32 +: 32] = wdata;
        if (wr_en && w >= 3 * NREG && w < 4 * NREG)
            clr_mask[(w - 3 * NREG) * 32 +: 32] = wdata;
    end

    assign hits = (rise_pulse & ren_q) | (fall_pulse & fen_q);

    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (pin_oe == '0 && pin_out == '0 && irq == 1'b0));

    p_dir_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !dir_wr |=> $stable(pin_oe));

    p_set_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (set_mask != '0) |=> ((pin_out & $past(set_mask)) == $past(set_mask)));

    p_clr_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_mask != '0) |=> ((pin_out & $past(clr_mask)) == '0));

    p_status_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((sts_q & ~$past(sts_q) & ~$past(hits)) == '0));

    p_edge_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (hits != '0) |=> ((sts_q & $past(hits)) == $past(hits)));

endmodule

bind gpio_bank_ctrl gpio_bank_chk #(.PIN_COUNT(PIN_COUNT), .ADDR_W(ADDR_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .addr       (addr),
    .wdata      (wdata),
    .pin_out    (pin_out),
    .pin_oe     (pin_oe),
    .irq        (irq),
    .sts_q      (sts_q),
    .rise_pulse (rise_pulse),
    .fall_pulse (fall_pulse),
    .ren_q      (ren_q),
    .fen_q      (fen_q)
);

// File: tb/gpio_bank_ctrl_tb_top.sv
// Directed bench for gpio_bank_ctrl, 64 pins. Every task starts and ends
// just after a falling clock edge; inputs change only there.
module gpio_bank_ctrl_tb_top;

    localparam int PINS   = 64;
    localparam int ADDR_W = 8;

    // Byte addresses for 64 pins (two words per feature).
    localparam logic [7:0] A_LVL0 = 8'h00, A_LVL1 = 8'h04;
    localparam logic [7:0] A_DIR0 = 8'h08, A_DIR1 = 8'h0C;
    localparam logic [7:0] A_SET0 = 8'h10, A_SET1 = 8'h14;
    localparam logic [7:0] A_CLR0 = 8'h18, A_CLR1 = 8'h1C;
    localparam logic [7:0] A_REN0 = 8'h20, A_REN1 = 8'h24;
    localparam logic [7:0] A_FEN1 = 8'h2C;
    localparam logic [7:0] A_STS0 = 8'h30, A_STS1 = 8'h34;
    localparam logic [7:0] A_AF0  = 8'h38, A_AF1 = 8'h3C, A_AF3 = 8'h44;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic              rd_en = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [31:0]       wdata = '0;
    logic [31:0]       rdata;
    logic [PINS-1:0]   pin_in = '0;
    logic [PINS-1:0]   pin_out;
    logic [PINS-1:0]   pin_oe;
    logic              irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    gpio_bank_ctrl #(.PIN_COUNT(PINS), .ADDR_W(ADDR_W)) dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .addr    (addr),
        .wdata   (wdata),
        .rdata   (rdata),
        .pin_in  (pin_in),
        .pin_out (pin_out),
        .pin_oe  (pin_oe),
        .irq     (irq)
    );

    task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        addr  = a;
        wdata = d;
        wr_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
        addr  = a;
        rd_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rd_en = 1'b0;
        d     = rdata;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R1 pin_oe after reset", pin_oe, '0);
        chk("R1 pin_out after reset", pin_out, '0);
        chk("R1 irq after reset", {63'd0, irq}, 64'd0);
        bus_rd(A_DIR1, d);  chk("R1 direction word 1", {32'd0, d}, 64'd0);
        bus_rd(A_STS0, d);  chk("R1 status word 0", {32'd0, d}, 64'd0);
        bus_rd(A_AF3, d);   chk("R1 altfn word 3", {32'd0, d}, 64'd0);
        bus_rd(A_REN0, d);  chk("R1 rise enable word 0", {32'd0, d}, 64'd0);
    endtask

    task automatic t_direction();
        logic [31:0] d;
        bus_wr(A_DIR1, 32'h8000_0001);
        chk("R3 pin_oe from word 1", pin_oe, 64'h8000_0001_0000_0000);
        bus_wr(A_DIR0, 32'h0000_00F0);
        chk("R3 pin_oe both words", pin_oe, 64'h8000_0001_0000_00F0);
        bus_rd(A_DIR1, d);
        chk("R2 direction word 1 readback", {32'd0, d}, 64'h8000_0001);
    endtask

    task automatic t_set_clear();
        logic [31:0] d;
        bus_wr(A_SET0, 32'h0000_00FF);
        chk("R4 set word 0", pin_out, 64'h0000_0000_0000_00FF);
        bus_wr(A_CLR0, 32'h0000_000F);
        chk("R4 clear word 0", pin_out, 64'h0000_0000_0000_00F0);
        bus_wr(A_SET1, 32'h0000_0001);
        chk("R4 set word 1", pin_out, 64'h0000_0001_0000_00F0);
        bus_wr(A_SET0, 32'h0);
        bus_wr(A_CLR1, 32'h0);
        chk("R4 zero data no change", pin_out, 64'h0000_0001_0000_00F0);
        bus_rd(A_SET0, d);  chk("R4 set word reads latch", {32'd0, d}, 64'h0000_00F0);
        bus_rd(A_CLR1, d);  chk("R4 clear word reads latch", {32'd0, d}, 64'h0000_0001);
    endtask

    task automatic t_level();
        logic [31:0] d;
        pin_in = 64'hA5A5_0001_1234_5678;
        idle(3);
        bus_rd(A_LVL0, d);  chk("R5 level word 0", {32'd0, d}, 64'h1234_5678);
        bus_rd(A_LVL1, d);  chk("R5 level word 1", {32'd0, d}, 64'hA5A5_0001);
        bus_wr(A_LVL0, 32'hFFFF_FFFF);
        bus_rd(A_LVL0, d);  chk("R5 level write ignored", {32'd0, d}, 64'h1234_5678);
        chk("R5 level write leaves pin_out", pin_out, 64'h0000_0001_0000_00F0);
        chk("R5 level write leaves pin_oe", pin_oe, 64'h8000_0001_0000_00F0);
        pin_in = '0;
        idle(4);
        bus_wr(A_STS0, 32'hFFFF_FFFF);
        bus_wr(A_STS1, 32'hFFFF_FFFF);
    endtask

    task automatic t_edges();
        logic [31:0] d;
        // pin 3 rising, pin 40 falling, pin 63 both
        bus_wr(A_REN0, 32'h0000_0008);
        bus_wr(A_REN1, 32'h8000_0000);
        bus_wr(A_FEN1, 32'h8000_0100);
        chk("R9 irq low with no status", {63'd0, irq}, 64'd0);
        pin_in = 64'h8000_0100_0000_0008;
        idle(4);
        bus_rd(A_STS0, d);  chk("R6 rising edge pin 3", {32'd0, d}, 64'h8);
        bus_rd(A_STS1, d);  chk("R6 rising only where enabled", {32'd0, d}, 64'h8000_0000);
        chk("R9 irq high with status", {63'd0, irq}, 64'd1);
        pin_in = '0;
        idle(4);
        bus_rd(A_STS0, d);  chk("R6 fall ignored on rise-only pin", {32'd0, d}, 64'h8);
        bus_rd(A_STS1, d);  chk("R6 falling edges pins 40 and 63", {32'd0, d}, 64'h8000_0100);
        bus_wr(A_STS0, 32'h0);
        bus_rd(A_STS0, d);  chk("R7 zero write keeps status", {32'd0, d}, 64'h8);
        bus_wr(A_STS0, 32'h8);
        bus_rd(A_STS0, d);  chk("R7 one write clears status", {32'd0, d}, 64'h0);
        chk("R9 irq held by word 1", {63'd0, irq}, 64'd1);
        bus_wr(A_STS1, 32'hFFFF_FFFF);
        chk("R9 irq low after all cleared", {63'd0, irq}, 64'd0);
    endtask

    task automatic t_same_cycle();
        logic [31:0] d;
        pin_in[3] = 1'b1;
        idle(4);
        pin_in[3] = 1'b0;
        idle(4);
        bus_rd(A_STS0, d);  chk("R8 setup status bit 3", {32'd0, d}, 64'h8);
        // new rising edge; clear lands on the edge where the pulse is high
        pin_in[3] = 1'b1;
        @(posedge clk); @(negedge clk);
        @(posedge clk); @(negedge clk);
        bus_wr(A_STS0, 32'h8);
        bus_rd(A_STS0, d);  chk("R8 edge beats same-cycle clear", {32'd0, d}, 64'h8);
        bus_wr(A_STS0, 32'h8);
        bus_rd(A_STS0, d);  chk("R7 later clear succeeds", {32'd0, d}, 64'h0);
        pin_in = '0;
        idle(4);
    endtask

    task automatic t_altfn();
        logic [31:0] d;
        bus_wr(A_AF1, 32'h0000_000C);   // pin 17 field = 3 at bits 3:2
        bus_wr(A_AF3, 32'hC000_0000);   // pin 63 field = 3 at bits 31:30
        bus_rd(A_AF1, d);  chk("R10 altfn pin 17 field", {32'd0, d}, 64'hC);
        bus_rd(A_AF3, d);  chk("R10 altfn pin 63 field", {32'd0, d}, 64'hC000_0000);
        bus_rd(A_AF0, d);  chk("R10 altfn other word untouched", {32'd0, d}, 64'h0);
        chk("R10 altfn leaves pin_out", pin_out, 64'h0000_0001_0000_00F0);
        chk("R10 altfn leaves pin_oe", pin_oe, 64'h8000_0001_0000_00F0);
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        bus_rd(A_DIR1, d);
        bus_rd(8'h48, d);  chk("R11 first unmapped word", {32'd0, d}, 64'h0);
        bus_rd(A_DIR1, d);
        bus_rd(8'hFC, d);  chk("R11 top unmapped word", {32'd0, d}, 64'h0);
    endtask

    initial begin
        idle(5);
        rst_n = 1'b1;
        idle(1);
        t_reset();
        t_direction();
        t_set_clear();
        t_level();
        t_edges();
        t_same_cycle();
        t_altfn();
        t_unmapped();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule